// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the full-width unsigned product of two WIDTH-bit operands. It does so one multiplier bit at a time, by conditional addition followed by a right shift. The surrounding system first writes the multiplicand and the multiplier from a shared data bus, using two separate load strobes. It then pulses a start input. The block reports that it is working on its busy output. When it finishes, it raises a one-cycle done pulse, and at that point the 2·WIDTH-bit result sits on the product output. The upper half of the product comes from the accumulator and the lower half from the multiplier register.

Inside, an accumulator with a separate carry flip-flop sits beside the multiplier shift register. A ripple adder adds the multiplicand into the accumulator. A down counter with a zero detect tracks how many bits remain. A small encoded-state controller steps through two states for each bit: a conditional-add state and a shift state. Each multiply therefore keeps the block busy for exactly 2·WIDTH cycles. While the block is idle, the product stays where it is until the multiplier register is written again.

Top module: `shiftadd_mult`

## Requirements
- R1: After a synchronous reset, busy and done are 0 and product is 0.
- R2: While idle, a high ld_mplier writes din into the multiplier register. din then appears on product[WIDTH-1:0] in the next cycle. A high ld_mcand writes din into the multiplicand register and leaves product unchanged.
- R3: A high go while idle makes busy high in the next cycle. busy never rises without go having been high in the cycle before.
- R4: Once started, busy stays high for exactly 2·WIDTH consecutive cycles.
- R5: In the cycle right after busy falls, done is high for exactly one cycle. In that cycle, product equals the unsigned product of the loaded multiplicand and multiplier, at full 2·WIDTH-bit width. done is never high while busy is high.
- R6: While idle with go and ld_mplier both low, product holds its value from one cycle to the next.
- R7: Inputs ld_mcand and ld_mplier are ignored while busy is high. The result of the multiply in progress is unaffected.
- R8: The carry out of each addition is kept and shifted back into the result. With both operands at all ones, the product is (2^WIDTH−1)^2.
- R9: A zero multiplicand or a zero multiplier gives a product of 0, with the same 2·WIDTH-cycle busy length.
- R10: A high go while busy neither restarts nor stretches the multiply in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_mcand | input | 1 | Write din into the multiplicand register (idle only) |
| ld_mplier | input | 1 | Write din into the multiplier register (idle only) |
| din | input | WIDTH | Shared operand bus |
| go | input | 1 | Start a multiply when idle |
| busy | output | 1 | High while a multiply is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2·WIDTH | Accumulator (upper half) and multiplier register (lower half) |

## Verification
The bound checker watches every cycle for the following:
- busy starts only after go.
- The busy run is exactly 2·WIDTH cycles long.
- done follows each falling edge of busy as a single pulse.
- The idle product holds still.
- The product at done matches operands shadowed from the load strobes while idle. This shadowing also covers the ignored loads of R7.

Some behaviour only the bench scenarios can show: the reset state and the lower-half effect of a multiplier load. They also cover the carry-heavy all-ones case, the zero-operand cases, and runs in which loads and go are hammered throughout the busy window.

// File: rtl/shiftadd_mult_pkg.sv
package shiftadd_mult_pkg;

    // Controller state codes; code 2'b11 is unused and decodes to nothing
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ADD   = 2'b01,
        ST_SHIFT = 2'b10,
        ST_BAD   = 2'b11
    } sam_state_e;

    // Decoded state lines plus the control strobes they produce
    typedef struct packed {
        logic idle;      // state decoder: idle
        logic in_add;    // state decoder: conditional-add state
        logic in_shift;  // state decoder: shift state
        logic init;      // clear accumulator and carry, preset counter
        logic add;       // accumulator <= accumulator + multiplicand
        logic clr_c;     // clear carry flip-flop
    } sam_ctrl_s;

    function automatic sam_ctrl_s sam_decode(input sam_state_e st,
                                             input logic go,
                                             input logic q0);
        sam_ctrl_s c;
        c.idle     = (st == ST_IDLE);
        c.in_add   = (st == ST_ADD);
        c.in_shift = (st == ST_SHIFT);
        c.init     = c.idle & go;
        c.add      = c.in_add & q0;
        c.clr_c    = c.init | c.in_shift;
        return c;
    endfunction

endpackage

// File: rtl/sam_adder.sv
module sam_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] s,
    output logic             cout
);
    logic [WIDTH:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign s[i]    = x[i] ^ y[i] ^ cy[i];
        assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
    end

    assign cout = cy[WIDTH];
endmodule

// File: rtl/sam_counter.sv
module sam_counter #(
    parameter int WIDTH = 8,
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic dec,
    output logic zero
);
    localparam logic [CNT_W-1:0] PRESET = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] p;

    always_ff @(posedge clk) begin
        if (rst)
            p <= '0;
        else if (init)
            p <= PRESET;
        else if (dec)
            p <= p - 1'b1;
    end

    // Zero detect on the value before any decrement of this cycle
    assign zero = (p == '0);
endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
    import shiftadd_mult_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  logic      q0,
    input  logic      zero,
    output sam_ctrl_s ctrl,
    output logic      busy,
    output logic      done
);
    sam_state_e st;
    sam_state_e st_nx;
    sam_ctrl_s  dec;

    always_comb dec = sam_decode(st, go, q0);

    // High bit: follows the add state. Low bit: a start, or a shift with bits left.
    // The unused code decodes to no state line and therefore falls to idle.
    always_comb begin
        st_nx = sam_state_e'({dec.in_add, dec.init | (dec.in_shift & ~zero)});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st   <= st_nx;
            done <= dec.in_shift & zero;
        end
    end

    assign ctrl = dec;
    assign busy = dec.in_add | dec.in_shift;
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath
    import shiftadd_mult_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  sam_ctrl_s          ctrl,
    input  logic               ld_b,
    input  logic               ld_q,
    input  logic [WIDTH-1:0]   din,
    output logic               q0,
    output logic [2*WIDTH-1:0] product
);
    logic [WIDTH-1:0] b_reg;
    logic [WIDTH-1:0] a_reg;
    logic [WIDTH-1:0] q_reg;
    logic             c_reg;
    logic [WIDTH-1:0] sum;
    logic             cout;

    sam_adder #(.WIDTH(WIDTH)) u_add (
        .x    (a_reg),
        .y    (b_reg),
        .s    (sum),
        .cout (cout)
    );

    // Multiplicand
    always_ff @(posedge clk) begin
        if (rst)
            b_reg <= '0;
        else if (ctrl.idle && ld_b)
            b_reg <= din;
    end

    // Accumulator and carry
    always_ff @(posedge clk) begin
        if (rst) begin
            a_reg <= '0;
            c_reg <= 1'b0;
        end else if (ctrl.init) begin
            a_reg <= '0;
            c_reg <= 1'b0;
        end else if (ctrl.add) begin
            a_reg <= sum;
            c_reg <= cout;
        end else if (ctrl.in_shift) begin
            a_reg <= {c_reg, a_reg[WIDTH-1:1]};
            c_reg <= 1'b0;
        end else if (ctrl.clr_c) begin
            c_reg <= 1'b0;
        end
    end

    // Multiplier shift register, refilled from the accumulator
    always_ff @(posedge clk) begin
        if (rst)
            q_reg <= '0;
        else if (ctrl.idle && ld_q)
            q_reg <= din;
        else if (ctrl.in_shift)
            q_reg <= {a_reg[0], q_reg[WIDTH-1:1]};
    end

    assign q0      = q_reg[0];
    assign product = {a_reg, q_reg};
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult
    import shiftadd_mult_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_mcand,
    input  logic               ld_mplier,
    input  logic [WIDTH-1:0]   din,
    input  logic               go,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    sam_ctrl_s ctrl;
    logic      q0;
    logic      zero;

    sam_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .q0   (q0),
        .zero (zero),
        .ctrl (ctrl),
        .busy (busy),
        .done (done)
    );

    sam_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .init (ctrl.init),
        .dec  (ctrl.in_shift),
        .zero (zero)
    );

    sam_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .ld_b    (ld_mcand),
        .ld_q    (ld_mplier),
        .din     (din),
        .q0      (q0),
        .product (product)
    );
endmodule

// File: rtl/shiftadd_mult_chk.sv
module shiftadd_mult_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               ld_mcand,
    input logic               ld_mplier,
    input logic [WIDTH-1:0]   din,
    input logic               go,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    logic [15:0]        busy_run;
    logic [WIDTH-1:0]   sh_b;
    logic [WIDTH-1:0]   sh_q;
    logic [2*WIDTH-1:0] want;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= '0;
            sh_b     <= '0;
            sh_q     <= '0;
        end else begin
            busy_run <= busy ? busy_run + 16'd1 : 16'd0;
            if (!busy && ld_mcand)  sh_b <= din;
            if (!busy && ld_mplier) sh_q <= din;
        end
    end

    always_comb want = {{WIDTH{1'b0}}, sh_b} * {{WIDTH{1'b0}}, sh_q};

    // R3
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && go) |=> busy);

    // R3
    rise_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go));

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == 16'(2*WIDTH)));

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R5 R7 (shadows update only while idle)
    product_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == want));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !go && !ld_mplier) |=> $stable(product));
endmodule

bind shiftadd_mult shiftadd_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_mcand  (ld_mcand),
    .ld_mplier (ld_mplier),
    .din       (din),
    .go        (go),
    .busy      (busy),
    .done      (done),
    .product   (product)
);

// File: tb/shiftadd_mult_test.sv
module shiftadd_mult_test;
    localparam int W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst;
    logic           ld_mcand;
    logic           ld_mplier;
    logic           go;
    logic [W-1:0]   din;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int checks   = 0;
    int fails    = 0;
    bit finished = 1'b0;

    shiftadd_mult #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .ld_mcand  (ld_mcand),
        .ld_mplier (ld_mplier),
        .din       (din),
        .go        (go),
        .busy      (busy),
        .done      (done),
        .product   (product)
    );

    task automatic check(input bit ok, input string req,
                         input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        return {{W{1'b0}}, x} * {{W{1'b0}}, y};
    endfunction

    task automatic run_mul(input logic [W-1:0] mc, input logic [W-1:0] mp,
                           input bit disturb, input string tag);
        int cycles;
        logic [2*W-1:0] held;
        @(negedge clk); din = mc; ld_mcand = 1'b1;
        @(negedge clk); ld_mcand = 1'b0; din = mp; ld_mplier = 1'b1;
        @(negedge clk); ld_mplier = 1'b0;
        check(product[W-1:0] == mp, "R2 multiplier load",
              {{W{1'b0}}, product[W-1:0]}, {{W{1'b0}}, mp});
        go = 1'b1;
        @(negedge clk); go = 1'b0;
        check(busy == 1'b1, "R3 start", {{(2*W-1){1'b0}}, busy}, 1);
        cycles = 0;
        while (busy && cycles < 1000) begin
            if (disturb) begin
                din = W'($urandom); ld_mcand = 1'b1; ld_mplier = 1'b1; go = 1'b1;
            end
            cycles++;
            @(negedge clk);
        end
        ld_mcand = 1'b0; ld_mplier = 1'b0; go = 1'b0;
        check(cycles == 2*W, {"R4 busy length ", tag}, (2*W)'(cycles), (2*W)'(2*W));
        check(done == 1'b1, {"R5 done pulse ", tag}, {{(2*W-1){1'b0}}, done}, 1);
        check(product == ref_mul(mc, mp), {"R5 product ", tag}, product, ref_mul(mc, mp));
        held = product;
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", {{(2*W-1){1'b0}}, done}, 0);
        check(product == held, "R6 idle hold after done", product, held);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] held;
        void'($urandom(32'h5A17_0C3D));
        rst = 1'b1; ld_mcand = 1'b0; ld_mplier = 1'b0; go = 1'b0; din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", {{(2*W-1){1'b0}}, busy}, 0);
        check(done == 1'b0, "R1 done after reset", {{(2*W-1){1'b0}}, done}, 0);
        check(product == '0, "R1 product after reset", product, 0);

        run_mul(8'd5,   8'd3,   1'b0, "5x3");
        run_mul(8'd255, 8'd255, 1'b0, "R8 all ones");
        run_mul(8'd0,   8'd200, 1'b0, "R9 zero multiplicand");
        run_mul(8'd200, 8'd0,   1'b0, "R9 zero multiplier");
        run_mul(8'd1,   8'd1,   1'b0, "1x1");
        run_mul(8'd128, 8'd2,   1'b0, "128x2");
        run_mul(8'd255, 8'd1,   1'b0, "255x1");
        run_mul(8'd173, 8'd219, 1'b1, "R7 R10 loads and go while busy");
        run_mul(8'd255, 8'd255, 1'b1, "R8 R10 all ones disturbed");

        // R6: idle, multiplicand writes and no go leave product alone
        held = product;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); din = W'($urandom); ld_mcand = 1'b1;
        end
        @(negedge clk); ld_mcand = 1'b0;
        check(product == held, "R6 idle hold under multiplicand writes", product, held);
        check(busy == 1'b0, "R6 stays idle without go", {{(2*W-1){1'b0}}, busy}, 0);

        for (int n = 0; n < 40; n++) begin
            run_mul(W'($urandom), W'($urandom), (n % 3) == 0, "random");
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule